// File: doc/BRIEF.md
# Interlaced Quadrature Acquisition Sequencer

This block drives the shared modulation-select line that steers each pixel's photon pulses into one of two counters. The modulation period is divided into four quarters of `QUARTER` clocks each, so one period is exactly `4*QUARTER` clocks. A position counter tracks where the current clock cycle falls within the period. A pulse on the reference marker realigns the position counter with the light source.

Frames alternate between two kinds. In the in-phase frame the select is high for the first half of the period, so the two counters collect the 0° and 180° samples. In the quadrature frame the select is delayed by exactly one quarter period, so the same two counters collect the 90° and 270° samples.

Each frame integrates over a configurable number of whole modulation periods. The block then withdraws its accumulation enable and raises a readout request. When the readout completes, it flips the frame tag and arms for the next frame. The frame tag travels with the read-out data so that downstream logic can tell which pair of samples it carries.

Top module: `iq_acq_seq`

## Requirements
- R1: While `rst_ni` is low, `acq_en_o`, `rd_req_o` and `phase_tag_o` are 0, the period position is 0 and `sel_o` is 1.
- R2: The period position advances by one each clock and wraps to 0 after `4*QUARTER` clocks. With `phase_tag_o`=0, `sel_o` is 1 for positions 0 to `2*QUARTER-1` and 0 for the rest of the period.
- R3: With `phase_tag_o`=1, `sel_o` is 1 for positions `QUARTER` to `3*QUARTER-1` and 0 elsewhere, which is the in-phase waveform delayed by one quarter period.
- R4: A one-cycle pulse on `ref_mark_i` in cycle t makes cycle t+1 position 0. If the block is armed, that cycle is also the first cycle of acquisition.
- R5: Acquisition starts at the first period boundary after arming, so `acq_en_o` rises at position 0. It then stays high for exactly `P*4*QUARTER` clocks, where P is `cfg_periods_i`, and a value of 0 counts as 1.
- R6: `rd_req_o` rises in the same cycle that `acq_en_o` falls. It holds until `rd_done_i` is sampled high, and `acq_en_o` stays 0 while it is high.
- R7: `phase_tag_o` inverts in the cycle after `rd_done_i` is sampled high during a pending request, and it is otherwise constant. Frames therefore alternate 0, 1, 0, and so on.
- R8: A pulse on `rd_done_i` while no request is pending has no effect on `phase_tag_o` or `rd_req_o`.
- R9: `cfg_periods_i` is captured at the start of each acquisition. Changing it during the acquisition does not change that frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, `4*QUARTER` cycles per modulation period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_mark_i | input | 1 | Reference marker; next cycle is period position 0 |
| rd_done_i | input | 1 | Readout of the current frame has finished |
| cfg_periods_i | input | CFG_W | Modulation periods integrated per frame (0 means 1) |
| sel_o | output | 1 | Modulation select to the pixel demultiplexers |
| acq_en_o | output | 1 | Accumulation enable for the pixel counters |
| phase_tag_o | output | 1 | Frame kind: 0 = 0°/180°, 1 = 90°/270° |
| rd_req_o | output | 1 | Full-frame readout request |

## Verification
The bench builds the block with `QUARTER`=4 and `CFG_W`=4, which gives a 16-clock period. With that setting, many wraps and both select waveforms are checked against the position on every cycle of a short run. The 4-bit count lets a frame's setting be raised mid-frame to a larger value, which tests the capture of the count at acquisition start. A count of 0 is also applied. The short period makes it cheap to place a reference marker partway through the armed wait and to send a stray readout-done between frames.

// File: rtl/iq_seq_pkg.sv
package iq_seq_pkg;
  typedef enum logic [1:0] {
    ST_ARM = 2'd0,
    ST_ACQ = 2'd1,
    ST_REQ = 2'd2
  } acq_state_e;
endpackage

// File: rtl/iq_period_timer.sv
module iq_period_timer #(
  parameter int QUARTER = 4,
  localparam int PERIOD = 4 * QUARTER,
  localparam int POS_W  = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_mark_i,
  output logic [POS_W-1:0] pos_o,
  output logic             bound_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PERIOD - 1);

  logic [POS_W-1:0] pos_q;

  // a boundary ends the current period: natural wrap or forced realign
  assign bound_o = ref_mark_i | (pos_q == LAST);
  assign pos_o   = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (bound_o) pos_q <= '0;
    else              pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/iq_sel_gen.sv
module iq_sel_gen #(
  parameter int QUARTER = 4,
  localparam int PERIOD = 4 * QUARTER,
  localparam int POS_W  = $clog2(PERIOD)
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             quad_i,
  output logic             sel_o
);
  localparam logic [POS_W:0] Q1 = (POS_W+1)'(QUARTER);
  localparam logic [POS_W:0] Q2 = (POS_W+1)'(2 * QUARTER);
  localparam logic [POS_W:0] Q3 = (POS_W+1)'(3 * QUARTER);

  logic [POS_W:0] pos_x;
  logic           sel_inph;
  logic           sel_quad;

  assign pos_x    = {1'b0, pos_i};
  assign sel_inph = pos_x < Q2;
  assign sel_quad = (pos_x >= Q1) && (pos_x < Q3);
  assign sel_o    = quad_i ? sel_quad : sel_inph;
endmodule

// File: rtl/iq_acq_ctrl.sv
module iq_acq_ctrl
  import iq_seq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bound_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rd_done_i,
  output logic             acq_en_o,
  output logic             rd_req_o,
  output logic             tag_o
);
  acq_state_e       state_q, state_d;
  logic [CFG_W-1:0] nper_q, nper_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             tag_q, tag_d;
  logic [CFG_W-1:0] cfg_eff;
  logic             last_per;

  assign cfg_eff  = (cfg_i == '0) ? CFG_W'(1) : cfg_i;
  assign last_per = (nper_q == cfg_q - 1'b1);

  always_comb begin
    state_d = state_q;
    nper_d  = nper_q;
    cfg_d   = cfg_q;
    tag_d   = tag_q;
    unique case (state_q)
      ST_ARM: if (bound_i) begin
        state_d = ST_ACQ;
        nper_d  = '0;
        cfg_d   = cfg_eff;
      end
      ST_ACQ: if (bound_i) begin
        if (last_per) state_d = ST_REQ;
        else          nper_d  = nper_q + 1'b1;
      end
      ST_REQ: if (rd_done_i) begin
        state_d = ST_ARM;
        tag_d   = ~tag_q;
      end
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      nper_q  <= '0;
      cfg_q   <= CFG_W'(1);
      tag_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nper_q  <= nper_d;
      cfg_q   <= cfg_d;
      tag_q   <= tag_d;
    end
  end

  assign acq_en_o = (state_q == ST_ACQ);
  assign rd_req_o = (state_q == ST_REQ);
  assign tag_o    = tag_q;
endmodule

// File: rtl/iq_acq_seq.sv
module iq_acq_seq #(
  parameter int QUARTER = 4,
  parameter int CFG_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_mark_i,
  input  logic             rd_done_i,
  input  logic [CFG_W-1:0] cfg_periods_i,
  output logic             sel_o,
  output logic             acq_en_o,
  output logic             phase_tag_o,
  output logic             rd_req_o
);
  localparam int POS_W = $clog2(4 * QUARTER);

  logic [POS_W-1:0] pos_w;
  logic             bound_w;
  logic             tag_w;

  iq_period_timer #(.QUARTER(QUARTER)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_mark_i (ref_mark_i),
    .pos_o      (pos_w),
    .bound_o    (bound_w)
  );

  iq_acq_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bound_i   (bound_w),
    .cfg_i     (cfg_periods_i),
    .rd_done_i (rd_done_i),
    .acq_en_o  (acq_en_o),
    .rd_req_o  (rd_req_o),
    .tag_o     (tag_w)
  );

  iq_sel_gen #(.QUARTER(QUARTER)) u_sel (
    .pos_i  (pos_w),
    .quad_i (tag_w),
    .sel_o  (sel_o)
  );

  assign phase_tag_o = tag_w;
endmodule

// File: rtl/iq_acq_seq_chk.sv
module iq_acq_seq_chk #(
  parameter int QUARTER = 4,
  localparam int POS_W  = $clog2(4 * QUARTER)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_mark_i,
  input logic             rd_done_i,
  input logic             sel_o,
  input logic             acq_en_o,
  input logic             phase_tag_o,
  input logic             rd_req_o,
  input logic [POS_W-1:0] pos_i
);
  localparam logic [POS_W-1:0] LAST = POS_W'(4 * QUARTER - 1);
  localparam logic [POS_W-1:0] QM1  = POS_W'(QUARTER - 1);

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_i == LAST |=> pos_i == '0);

  p_rise_inph_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_tag_o && pos_i == LAST && !(rd_req_o && rd_done_i)) |=> $rose(sel_o));

  p_rise_quad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_tag_o && pos_i == QM1 && !ref_mark_i && !(rd_req_o && rd_done_i))
      |=> $rose(sel_o));

  p_mark_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_mark_i |=> pos_i == '0);

  p_acq_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_en_o) |-> pos_i == '0);

  p_req_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !acq_en_o);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_done_i) |=> rd_req_o);

  p_req_after_acq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acq_en_o) |-> rd_req_o);

  p_tag_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_done_i) |=> phase_tag_o != $past(phase_tag_o));

  p_tag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && rd_done_i) |=> $stable(phase_tag_o));
endmodule

bind iq_acq_seq iq_acq_seq_chk #(.QUARTER(QUARTER)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_mark_i  (ref_mark_i),
  .rd_done_i   (rd_done_i),
  .sel_o       (sel_o),
  .acq_en_o    (acq_en_o),
  .phase_tag_o (phase_tag_o),
  .rd_req_o    (rd_req_o),
  .pos_i       (pos_w)
);

// File: tb/tb_iq_acq_seq.sv
module tb_iq_acq_seq;
  localparam int QUARTER = 4;
  localparam int CFG_W   = 4;
  localparam int PERIOD  = 4 * QUARTER;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_mark_i = 1'b0;
  logic             rd_done_i = 1'b0;
  logic [CFG_W-1:0] cfg_periods_i = '0;
  logic             sel_o, acq_en_o, phase_tag_o, rd_req_o;

  int n_chk = 0;
  int n_err = 0;
  int pos   = 0;
  bit exp_tag = 1'b0;

  typedef struct {int len; bit tag;} exp_t;
  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  iq_acq_seq #(.QUARTER(QUARTER), .CFG_W(CFG_W)) dut (
    .clk_i, .rst_ni, .ref_mark_i, .rd_done_i, .cfg_periods_i,
    .sel_o, .acq_en_o, .phase_tag_o, .rd_req_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // period position as the requirements define it (R2, R4)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos <= 0;
    else if (ref_mark_i)      pos <= 0;
    else if (pos == PERIOD-1) pos <= 0;
    else                      pos <= pos + 1;
  end

  // monitor: select waveform every cycle, acquisition windows against scoreboard
  int  run = 0;
  bit  run_tag = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (phase_tag_o == 1'b0)
        check(sel_o == (pos < 2*QUARTER), "R2 sel in-phase", int'(sel_o), int'(pos < 2*QUARTER));
      else
        check(sel_o == (pos >= QUARTER && pos < 3*QUARTER), "R3 sel quadrature",
              int'(sel_o), int'(pos >= QUARTER && pos < 3*QUARTER));
      if (acq_en_o) begin
        if (run == 0) begin
          check(pos == 0, "R5 start at position 0", pos, 0);
          run_tag = phase_tag_o;
        end
        check(!rd_req_o, "R6 no request during acquisition", int'(rd_req_o), 0);
        check(phase_tag_o == run_tag, "R7 tag constant in frame", int'(phase_tag_o), int'(run_tag));
        run++;
      end else if (run > 0) begin
        check(rd_req_o, "R6 request when acquisition ends", int'(rd_req_o), 1);
        if (sb_q.size() == 0) begin
          check(1'b0, "R5 unexpected frame", run, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(run == e.len, "R5/R9 frame length", run, e.len);
          check(run_tag == e.tag, "R7 frame tag", int'(run_tag), int'(e.tag));
        end
        run = 0;
      end
    end
  end

  task automatic frame(input int cfg, input bit stray_done, input int cfg_late);
    exp_t e;
    e.len = ((cfg == 0) ? 1 : cfg) * PERIOD;
    e.tag = exp_tag;
    sb_q.push_back(e);
    cfg_periods_i = CFG_W'(cfg);
    if (stray_done) begin
      rd_done_i = 1'b1;
      @(negedge clk_i);
      rd_done_i = 1'b0;
      check(phase_tag_o == exp_tag, "R8 stray done keeps tag", int'(phase_tag_o), int'(exp_tag));
      check(!rd_req_o, "R8 stray done no request", int'(rd_req_o), 0);
    end
    if (cfg_late >= 0) begin
      while (!acq_en_o) @(negedge clk_i);
      @(negedge clk_i);
      cfg_periods_i = CFG_W'(cfg_late);  // R9: must not alter this frame
    end
    while (!rd_req_o) @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(rd_req_o && !acq_en_o, "R6 request held, enable low", int'(rd_req_o), 1);
    end
    rd_done_i = 1'b1;
    @(negedge clk_i);
    rd_done_i = 1'b0;
    check(!rd_req_o, "R6 request drops after done", int'(rd_req_o), 0);
    check(phase_tag_o == !exp_tag, "R7 tag flips after readout", int'(phase_tag_o), int'(!exp_tag));
    exp_tag = !exp_tag;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!acq_en_o, "R1 reset enable", int'(acq_en_o), 0);
    check(!rd_req_o, "R1 reset request", int'(rd_req_o), 0);
    check(!phase_tag_o, "R1 reset tag", int'(phase_tag_o), 0);
    check(sel_o, "R1 reset select", int'(sel_o), 1);
    rst_ni = 1'b1;

    // R4: marker partway through the armed wait starts acquisition early
    cfg_periods_i = CFG_W'(2);
    while (pos != 5) @(negedge clk_i);
    check(!acq_en_o, "R4 still armed before marker", int'(acq_en_o), 0);
    begin
      exp_t e;
      e.len = 2 * PERIOD;
      e.tag = 1'b0;
      sb_q.push_back(e);
    end
    ref_mark_i = 1'b1;
    @(negedge clk_i);
    ref_mark_i = 1'b0;
    check(acq_en_o && pos == 0, "R4 marker realigns and starts", int'(acq_en_o), 1);
    while (!rd_req_o) @(negedge clk_i);
    @(negedge clk_i);
    rd_done_i = 1'b1;
    @(negedge clk_i);
    rd_done_i = 1'b0;
    check(phase_tag_o == 1'b1, "R7 first flip", int'(phase_tag_o), 1);
    exp_tag = 1'b1;

    frame(1, 1'b1, -1);  // quadrature, stray done while armed (R8)
    frame(0, 1'b0, -1);  // zero counts as one period (R5)
    frame(2, 1'b0, 7);   // late change ignored (R9)
    frame(3, 1'b1, -1);

    repeat (4) @(negedge clk_i);
    check(sb_q.size() == 0, "R5 all frames seen", sb_q.size(), 0);
    finish_run();
  end
endmodule